// File: doc/BRIEF.md
# Branch Source Trace Queue

This block keeps a short history of where the processor last branched from, for use by a debugger. Each time the core reports a taken branch while tracing is on, the block captures the low 28 bits of the branching instruction's address. That capture goes into the head slot. Everything already held moves one slot further back, and whatever sat in the last slot is dropped. The history is a shift chain of four slots, not a pointer FIFO.

Debug software reads any slot by index as a 32-bit word. Each slot has a valid flag that marks whether its address means anything. A slot's flag clears when software reads that slot. All flags clear when tracing is switched on and on a power-on reset. The stored address bits have no reset and survive both kinds of reset.

A separate normal (system) reset stops the block from recording branches and from acting on reads while it is held. It leaves the stored history untouched.

Top module: `brtrace_queue`

## Requirements
- R1: `rd_data` shows slot `rd_idx` in the same cycle, whatever the state of `rd_en`. Bit 31 is the slot's valid flag, bits 27..0 are its stored address and bits 30..28 are 0. Slot 0 is the newest.
- R2: While `por_n` is low, all four valid flags are 0.
- R3: A branch (`br_take`=1) with `trace_en`=1 and `rst_n`=1 loads `br_addr[27:0]` into slot 0 and sets its flag at that clock edge.
- R4: On a recorded branch, slot k (k=1..3) takes the address and flag that slot k-1 held, and the old contents of slot 3 are lost.
- R5: A branch while `trace_en`=0 changes no slot.
- R6: A clock edge with `rd_en`=1 clears the flag of slot `rd_idx`. It keeps that slot's address and leaves the other slots alone.
- R7: At the first edge after `trace_en` goes from 0 to 1, all flags clear. A branch in that same cycle is still recorded in slot 0 with its flag set.
- R8: When a branch and a read fall in the same cycle, the read returns the contents from before the shift. The read slot's cleared flag then moves on with its address, to slot `rd_idx`+1.
- R9: While `rst_n`=0, branches and reads change no slot, and all stored addresses and flags are kept.
- R10: Power-on reset does not change the stored address bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| rst_n | input | 1 | Normal reset, active low; holds off recording and reads |
| trace_en | input | 1 | Trace enable; a rising level clears all flags |
| br_take | input | 1 | Taken-branch strobe from the core |
| br_addr | input | 32 | Address of the branching instruction |
| rd_en | input | 1 | Read strobe; clears the selected slot's flag |
| rd_idx | input | 2 | Slot index to read (0 = newest) |
| rd_data | output | 32 | Selected slot: flag, zero pad, address |

## Verification
A shift and a read-clear can fall in the same cycle. The vector walk provokes this by asserting `br_take` and `rd_en` together on slot 2. In that cycle the bench compares `rd_data` with the contents from before the shift. It then reads slot 3 without `rd_en` and expects the address that was read, now with its flag clear. A second collision puts a branch on the very cycle that `trace_en` rises. The bench then expects slot 0 to hold the new address as valid and every older slot to be invalid.

// File: rtl/brtq_pkg.sv
package brtq_pkg;

   localparam int unsigned DEF_DEPTH     = 4;
   localparam int unsigned DEF_ADDR_W    = 32;
   localparam int unsigned DEF_KEEP_W    = 28;
   localparam int unsigned DEF_DATA_W    = 32;
   localparam int unsigned DEF_VALID_BIT = 31;

   // per-cycle control strobes shared by every slot
   typedef struct packed {
      logic shift;    // recorded branch: move history back one slot
      logic clr_all;  // trace just enabled: drop every flag
   } brtq_ctl_t;

endpackage

// File: rtl/brtq_ctrl.sv
module brtq_ctrl
   import brtq_pkg::*;
(
   input  logic      clk,
   input  logic      por_n,
   input  logic      rst_n,
   input  logic      trace_en,
   input  logic      br_take,
   input  logic      rd_en,
   output brtq_ctl_t ctl,
   output logic      rd_clr
);

   logic en_q;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) en_q <= 1'b0;
      else        en_q <= trace_en;
   end

   always_comb begin
      ctl.shift   = br_take & trace_en & rst_n;
      ctl.clr_all = trace_en & ~en_q;
      rd_clr      = rd_en & rst_n;
   end

   // R7: the enable edge lasts one cycle only
   a_r7_edge_single: assert property (@(posedge clk) disable iff (!por_n)
      ctl.clr_all |=> !ctl.clr_all);

endmodule

// File: rtl/brtq_cell.sv
module brtq_cell #(
   parameter int unsigned KEEP_W = brtq_pkg::DEF_KEEP_W
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              shift,
   input  logic              clr_all,
   input  logic              clr_this,
   input  logic [KEEP_W-1:0] up_addr,
   input  logic              up_valid,
   output logic [KEEP_W-1:0] addr,
   output logic              valid,
   output logic              kept_valid
);

   // address bits carry no reset on purpose
   always_ff @(posedge clk) begin
      if (shift) addr <= up_addr;
   end

   assign kept_valid = valid & ~clr_this & ~clr_all;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)     valid <= 1'b0;
      else if (shift) valid <= up_valid;
      else            valid <= kept_valid;
   end

   a_r4_take_upstream: assert property (@(posedge clk) disable iff (!por_n)
      shift |=> (addr == $past(up_addr)) && (valid == $past(up_valid)));
   a_r6_read_clears: assert property (@(posedge clk) disable iff (!por_n)
      (clr_this && !shift) |=> !valid);
   a_r7_all_clear: assert property (@(posedge clk) disable iff (!por_n)
      (clr_all && !shift) |=> !valid);
   a_r10_addr_hold: assert property (@(posedge clk) disable iff (!por_n)
      !shift |=> $stable(addr));

endmodule

// File: rtl/brtq_rdmux.sv
module brtq_rdmux #(
   parameter int unsigned DEPTH     = brtq_pkg::DEF_DEPTH,
   parameter int unsigned KEEP_W    = brtq_pkg::DEF_KEEP_W,
   parameter int unsigned DATA_W    = brtq_pkg::DEF_DATA_W,
   parameter int unsigned VALID_BIT = brtq_pkg::DEF_VALID_BIT,
   localparam int unsigned IDX_W    = $clog2(DEPTH)
) (
   input  logic [DEPTH*KEEP_W-1:0] addr_flat,
   input  logic [DEPTH-1:0]        valid_vec,
   input  logic [IDX_W-1:0]        idx,
   output logic [DATA_W-1:0]       data
);

   logic [KEEP_W-1:0] sel_addr;
   logic              sel_valid;

   always_comb begin
      sel_addr  = addr_flat[idx*KEEP_W +: KEEP_W];
      sel_valid = valid_vec[idx];
      data                 = '0;
      data[KEEP_W-1:0]     = sel_addr;
      data[VALID_BIT]      = sel_valid;
   end

endmodule

// File: rtl/brtrace_queue.sv
module brtrace_queue
   import brtq_pkg::*;
#(
   parameter int unsigned DEPTH     = DEF_DEPTH,
   parameter int unsigned ADDR_W    = DEF_ADDR_W,
   parameter int unsigned KEEP_W    = DEF_KEEP_W,
   parameter int unsigned DATA_W    = DEF_DATA_W,
   parameter int unsigned VALID_BIT = DEF_VALID_BIT,
   localparam int unsigned IDX_W    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              rst_n,
   input  logic              trace_en,
   input  logic              br_take,
   input  logic [ADDR_W-1:0] br_addr,
   input  logic              rd_en,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_data
);

   initial begin
      assert (DEPTH >= 2 && (1 << IDX_W) == DEPTH)
         else $error("DEPTH must be a power of two, at least 2");
      assert (KEEP_W <= ADDR_W && KEEP_W < VALID_BIT && VALID_BIT < DATA_W)
         else $error("field widths do not fit the read word");
   end

   brtq_ctl_t ctl;
   logic      rd_clr;

   brtq_ctrl u_ctrl (
      .clk      (clk),
      .por_n    (por_n),
      .rst_n    (rst_n),
      .trace_en (trace_en),
      .br_take  (br_take),
      .rd_en    (rd_en),
      .ctl      (ctl),
      .rd_clr   (rd_clr)
   );

   logic [DEPTH*KEEP_W-1:0] addr_flat;
   logic [DEPTH-1:0]        valid_vec;
   logic [DEPTH-1:0]        kept_vec;
   logic [DEPTH-1:0]        clr_sel;
   logic                    unused_addr_hi;

   if (KEEP_W < ADDR_W) begin : g_hi
      assign unused_addr_hi = ^br_addr[ADDR_W-1:KEEP_W];
   end else begin : g_nohi
      assign unused_addr_hi = 1'b0;
   end

   for (genvar k = 0; k < DEPTH; k++) begin : g_slot
      logic [KEEP_W-1:0] up_a;
      logic              up_v;
      assign clr_sel[k] = rd_clr && (rd_idx == IDX_W'(k));
      if (k == 0) begin : g_head
         assign up_a = br_addr[KEEP_W-1:0];
         assign up_v = 1'b1;
      end else begin : g_tail
         assign up_a = addr_flat[(k-1)*KEEP_W +: KEEP_W];
         assign up_v = kept_vec[k-1];
      end
      brtq_cell #(.KEEP_W(KEEP_W)) u_cell (
         .clk        (clk),
         .por_n      (por_n),
         .shift      (ctl.shift),
         .clr_all    (ctl.clr_all),
         .clr_this   (clr_sel[k]),
         .up_addr    (up_a),
         .up_valid   (up_v),
         .addr       (addr_flat[k*KEEP_W +: KEEP_W]),
         .valid      (valid_vec[k]),
         .kept_valid (kept_vec[k])
      );
   end

   brtq_rdmux #(
      .DEPTH(DEPTH), .KEEP_W(KEEP_W), .DATA_W(DATA_W), .VALID_BIT(VALID_BIT)
   ) u_rdmux (
      .addr_flat (addr_flat),
      .valid_vec (valid_vec),
      .idx       (rd_idx),
      .data      (rd_data)
   );

   a_r3_head_loaded: assert property (@(posedge clk) disable iff (!por_n)
      (br_take && trace_en && rst_n) |=>
         valid_vec[0] && (addr_flat[KEEP_W-1:0] == $past(br_addr[KEEP_W-1:0])));
   a_r5_off_frozen: assert property (@(posedge clk) disable iff (!por_n)
      !trace_en |=> $stable(addr_flat));
   a_r9_sysrst_hold: assert property (@(posedge clk) disable iff (!por_n)
      (!rst_n && !ctl.clr_all) |=> $stable(addr_flat) && $stable(valid_vec));
   a_r2_por_flags: assert property (@(posedge clk)
      !por_n |-> (valid_vec == '0));

endmodule

// File: tb/brtrace_queue_test.sv
module brtrace_queue_test;

   logic        clk = 1'b0;
   logic        por_n, rst_n, trace_en, br_take, rd_en;
   logic [31:0] br_addr;
   logic [1:0]  rd_idx;
   logic [31:0] rd_data;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   brtrace_queue uut (
      .clk(clk), .por_n(por_n), .rst_n(rst_n), .trace_en(trace_en),
      .br_take(br_take), .br_addr(br_addr), .rd_en(rd_en),
      .rd_idx(rd_idx), .rd_data(rd_data)
   );

   task automatic chk(input logic [31:0] mask, input logic [31:0] exp, input string req);
      checks++;
      if ((rd_data & mask) !== (exp & mask)) begin
         errors++;
         $display("FAIL %s: got %h expected %h (mask %h)", req, rd_data & mask, exp & mask, mask);
      end
   endtask

   // row: br, addr, ren, idx, ten, rstn, expected rd_data before the edge
   localparam int NV = 18;
   localparam logic [69:0] VEC [NV] = '{
      {1'b0, 32'h0000_0000, 1'b0, 2'd3, 1'b1, 1'b1, 32'h8000_0100}, // R1 oldest
      {1'b1, 32'hF000_0500, 1'b0, 2'd0, 1'b1, 1'b1, 32'h8000_0400}, // R3 branch
      {1'b0, 32'h0000_0000, 1'b0, 2'd3, 1'b1, 1'b1, 32'h8000_0200}, // R4 oldest dropped
      {1'b0, 32'h0000_0000, 1'b1, 2'd1, 1'b1, 1'b1, 32'h8000_0400}, // R6 read slot 1
      {1'b0, 32'h0000_0000, 1'b0, 2'd1, 1'b1, 1'b1, 32'h0000_0400}, // R6 flag cleared
      {1'b0, 32'h0000_0000, 1'b0, 2'd2, 1'b1, 1'b1, 32'h8000_0300}, // R6 others kept
      {1'b1, 32'h0ABC_DEF1, 1'b1, 2'd2, 1'b1, 1'b1, 32'h8000_0300}, // R8 old data
      {1'b0, 32'h0000_0000, 1'b0, 2'd3, 1'b1, 1'b1, 32'h0000_0300}, // R8 flag moved
      {1'b0, 32'h0000_0000, 1'b0, 2'd0, 1'b1, 1'b1, 32'h8ABC_DEF1}, // R3 head
      {1'b1, 32'h1234_5678, 1'b1, 2'd0, 1'b1, 1'b0, 32'h8ABC_DEF1}, // R9 under sys reset
      {1'b0, 32'h0000_0000, 1'b0, 2'd0, 1'b1, 1'b1, 32'h8ABC_DEF1}, // R9 head kept
      {1'b0, 32'h0000_0000, 1'b0, 2'd1, 1'b1, 1'b1, 32'h8000_0500}, // R9 no shift
      {1'b1, 32'hFFFF_FFFF, 1'b0, 2'd0, 1'b0, 1'b1, 32'h8ABC_DEF1}, // R5 trace off
      {1'b0, 32'h0000_0000, 1'b0, 2'd1, 1'b0, 1'b1, 32'h8000_0500}, // R5 no shift
      {1'b1, 32'h0000_0777, 1'b0, 2'd0, 1'b1, 1'b1, 32'h8ABC_DEF1}, // R7 enable + branch
      {1'b0, 32'h0000_0000, 1'b0, 2'd0, 1'b1, 1'b1, 32'h8000_0777}, // R7 new head valid
      {1'b0, 32'h0000_0000, 1'b0, 2'd1, 1'b1, 1'b1, 32'h0ABC_DEF1}, // R7 older cleared
      {1'b0, 32'h0000_0000, 1'b0, 2'd3, 1'b1, 1'b1, 32'h0000_0400}  // R7 oldest cleared
   };

   initial begin
      #400000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog: got hang expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      por_n = 1'b0; rst_n = 1'b1; trace_en = 1'b0; br_take = 1'b0;
      br_addr = '0; rd_en = 1'b0; rd_idx = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      por_n = 1'b1;
      #1;
      for (int i = 0; i < 4; i++) begin
         rd_idx = 2'(i);
         #0.1;
         chk(32'hF000_0000, 32'h0000_0000, "R2 flag after power-on");
      end
      // enable trace, then fill with four known addresses
      @(negedge clk); trace_en = 1'b1;
      @(negedge clk); br_take = 1'b1; br_addr = 32'h0000_0100;
      @(negedge clk); br_addr = 32'h1000_0200;
      @(negedge clk); br_addr = 32'h2000_0300;
      @(negedge clk); br_addr = 32'h3000_0400;
      for (int v = 0; v < NV; v++) begin
         @(negedge clk);
         {br_take, br_addr, rd_en, rd_idx, trace_en, rst_n} = VEC[v][69:32];
         #1;
         chk(32'hFFFF_FFFF, VEC[v][31:0], $sformatf("vector %0d", v));
      end
      // R10: power-on reset drops flags, keeps address bits
      @(negedge clk);
      br_take = 1'b0; rd_en = 1'b0; rd_idx = 2'd0; por_n = 1'b0;
      #1;
      chk(32'hFFFF_FFFF, 32'h0000_0777, "R10 addr kept, R2 flag clear");
      rd_idx = 2'd1;
      #0.1;
      chk(32'hFFFF_FFFF, 32'h0ABC_DEF1, "R10 slot 1 addr kept");
      @(negedge clk); por_n = 1'b1;
      @(negedge clk); rd_idx = 2'd0;
      #1;
      chk(32'hFFFF_FFFF, 32'h0000_0777, "R10 after release");
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule